// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This block watches a DRAM controller through a set of single-cycle event strobes and counts them in a small bank of counters that software configures and reads through a plain register port. Each counter has a control word holding an enable, a one-shot clear request and an 8-bit event code; its count is read back at a separate address. Counter 0 always counts clock cycles and serves as the timebase for the whole unit: the other counters advance only while it is enabled, and it alone can raise the interrupt.

When counter 0 rolls over it latches an overflow flag, drives the interrupt high and freezes every counter until software re-arms counter 0 with a write that sets both enable and clear. The remaining counters roll over silently. Two event codes are qualified by a transaction ID held in a filter register, so read or write transactions of one master can be counted.

The register port has no handshake: a write takes effect at the clock edge where the write strobe is high, and the read data follows the address combinationally.

Top module: `dram_pmon`

## Requirements
- R1: While reset is asserted and after it is released, every register reads 0, all counters are disabled and the interrupt output is low.
- R2: Register map: control word of counter n at byte address 4·n, count of counter n at 0x20 + 4·n, filter at 0x30, all other addresses read 0 and ignore writes. Control fields: bit 2 enable, bits 31:24 event code, bit 1 clear request (always reads 0), bit 0 overflow flag (counter 0 only, not settable by software, reads 0 on counters 1 to 3).
- R3: A control write with bit 1 set zeroes that counter at the write edge; counting resumes on the next edge if bit 2 is set.
- R4: Counter 0 adds one on every clock edge where it is enabled and not frozen, whatever its event code.
- R5: Counters 1 to 3 add one on each edge where they are enabled and the selected strobe is high; codes 1 to 63 select event line number equal to the code; code 0 and codes that match no source never count.
- R6: Counters 1 to 3 hold their value while counter 0 is disabled, even if their strobe is high.
- R7: Code 0x41 counts cycles with a read transaction whose ID equals the filter register; code 0x42 does the same for write transactions.
- R8: A rollover of counter 0 sets its overflow flag and the interrupt on the next edge and stops all counters; a control-0 write with enable and clear both set restarts them.
- R9: Counters 1 to 3 roll over from all ones to 0 without setting any flag or the interrupt.
- R10: A control-0 write with bit 0 clear drops the overflow flag and the interrupt; writing 0 to any control word disables that counter and its count stays readable.
- R11: A control write with enable set and clear not set resumes counting from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| evt_lines | input | NUM_LINES | Event strobes, line k selected by event code k |
| rd_txn_vld | input | 1 | A read transaction is seen this cycle |
| rd_txn_id | input | ID_W | ID of that read transaction |
| wr_txn_vld | input | 1 | A write transaction is seen this cycle |
| wr_txn_id | input | ID_W | ID of that write transaction |
| irq | output | 1 | Level interrupt, high while counter 0's overflow flag is set |

## Verification
The hardest situation to reach is the rollover of the cycle counter, since at full width it needs four billion cycles, and its interplay with a second counter that must itself be seen rolling over silently while the cycle counter keeps running. The bench builds the unit with an 8-bit counter width, re-arms counter 0 midway through a long strobe burst so counter 1 wraps while counter 0 does not, and then lets counter 0 wrap with a strobe offset by one cycle so the frozen value of counter 1 is distinct from zero. It then clears the flag without re-arming to show that the freeze survives the flag clear.

// File: rtl/dram_pmon_pkg.sv
package dram_pmon_pkg;

  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] CTL_BASE  = 8'h00;
  localparam logic [REG_AW-1:0] CNT_BASE  = 8'h20;
  localparam logic [REG_AW-1:0] FILT_ADDR = 8'h30;

  localparam int BIT_OVF  = 0;
  localparam int BIT_CLR  = 1;
  localparam int BIT_EN   = 2;
  localparam int CODE_LSB = 24;

  localparam logic [7:0] EV_CYCLES = 8'h00;
  localparam logic [7:0] EV_ID_RD  = 8'h41;
  localparam logic [7:0] EV_ID_WR  = 8'h42;

  typedef struct packed {
    logic       en;
    logic [7:0] code;
  } ctl_t;

endpackage

// File: rtl/dram_pmon_ctl.sv
module dram_pmon_ctl
  import dram_pmon_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int ID_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [REG_DW-1:0]        reg_wdata,
  input  logic                     wrap0,
  output ctl_t [NUM_CNT-1:0]       ctl_q,
  output logic [NUM_CNT-1:0]       clr,
  output logic                     ovf_q,
  output logic                     halt_q,
  output logic [ID_W-1:0]          filt_q
);

  logic [NUM_CNT-1:0] hit;
  ctl_t [NUM_CNT-1:0] ctl_d;
  logic               ovf_d;
  logic               ovf_ce;
  logic               halt_d;
  logic               halt_ce;
  logic               filt_ce;
  logic               rearm;

  always_comb begin
    for (int n = 0; n < NUM_CNT; n++) begin
      hit[n]        = reg_we && (reg_addr == CTL_BASE + 8'(4 * n));
      clr[n]        = hit[n] && reg_wdata[BIT_CLR];
      ctl_d[n].en   = reg_wdata[BIT_EN];
      ctl_d[n].code = reg_wdata[CODE_LSB +: 8];
    end
  end

  // overflow flag: hardware set wins over a software clear in the same cycle
  always_comb begin
    ovf_d  = ovf_q;
    ovf_ce = 1'b0;
    if (wrap0) begin
      ovf_d  = 1'b1;
      ovf_ce = 1'b1;
    end else if (hit[0] && !reg_wdata[BIT_OVF]) begin
      ovf_d  = 1'b0;
      ovf_ce = 1'b1;
    end
  end

  // freeze: only a full re-arm of counter 0 lifts it
  assign rearm = hit[0] && reg_wdata[BIT_CLR] && reg_wdata[BIT_EN];

  always_comb begin
    halt_d  = halt_q;
    halt_ce = 1'b0;
    if (wrap0) begin
      halt_d  = 1'b1;
      halt_ce = 1'b1;
    end else if (rearm) begin
      halt_d  = 1'b0;
      halt_ce = 1'b1;
    end
  end

  assign filt_ce = reg_we && (reg_addr == FILT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      ovf_q  <= 1'b0;
      halt_q <= 1'b0;
      filt_q <= '0;
    end else begin
      for (int n = 0; n < NUM_CNT; n++) begin
        if (hit[n]) ctl_q[n] <= ctl_d[n];
      end
      if (ovf_ce)  ovf_q  <= ovf_d;
      if (halt_ce) halt_q <= halt_d;
      if (filt_ce) filt_q <= reg_wdata[ID_W-1:0];
    end
  end

endmodule

// File: rtl/dram_pmon_evsel.sv
module dram_pmon_evsel
  import dram_pmon_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ID_W      = 32
) (
  input  logic [7:0]           code,
  input  logic [NUM_LINES-1:0] evt_lines,
  input  logic                 rd_txn_vld,
  input  logic [ID_W-1:0]      rd_txn_id,
  input  logic                 wr_txn_vld,
  input  logic [ID_W-1:0]      wr_txn_id,
  input  logic [ID_W-1:0]      filt,
  output logic                 ev_hit
);

  localparam int         LINE_IW  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [8:0] LINE_LIM = 9'(NUM_LINES);

  logic code_in_lines;

  assign code_in_lines = ({1'b0, code} < LINE_LIM) && (code != EV_CYCLES);

  always_comb begin
    ev_hit = 1'b0;
    if (code == EV_ID_RD) begin
      ev_hit = rd_txn_vld && (rd_txn_id == filt);
    end else if (code == EV_ID_WR) begin
      ev_hit = wr_txn_vld && (wr_txn_id == filt);
    end else if (code_in_lines) begin
      ev_hit = evt_lines[code[LINE_IW-1:0]];
    end
  end

endmodule

// File: rtl/dram_pmon_cnt.sv
module dram_pmon_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = clr || run;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dram_pmon.sv
module dram_pmon
  import dram_pmon_pkg::*;
#(
  parameter int NUM_CNT   = 4,
  parameter int CNT_W     = 32,
  parameter int NUM_LINES = 64,
  parameter int ID_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [7:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] evt_lines,
  input  logic                 rd_txn_vld,
  input  logic [ID_W-1:0]      rd_txn_id,
  input  logic                 wr_txn_vld,
  input  logic [ID_W-1:0]      wr_txn_id,
  output logic                 irq
);

  localparam int FLAT_W = NUM_CNT * CNT_W;

  logic [1:0]                    rst_pipe;
  logic                          rst_s;
  ctl_t [NUM_CNT-1:0]            ctl_q;
  logic [NUM_CNT-1:0]            clr;
  logic [NUM_CNT-1:0]            run;
  logic [NUM_CNT-1:1]            ev_hit;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [FLAT_W-1:0]             cnt_flat;
  logic                          ovf_q;
  logic                          halt_q;
  logic [ID_W-1:0]               filt_q;
  logic                          master_en;
  logic                          wrap0;

  // reset: asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s = rst_pipe[1];

  dram_pmon_ctl #(
    .NUM_CNT (NUM_CNT),
    .ID_W    (ID_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_s),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wrap0     (wrap0),
    .ctl_q     (ctl_q),
    .clr       (clr),
    .ovf_q     (ovf_q),
    .halt_q    (halt_q),
    .filt_q    (filt_q)
  );

  assign master_en = ctl_q[0].en;
  assign wrap0     = run[0] && !clr[0] && (cnt_q[0] == {CNT_W{1'b1}});

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    if (n == 0) begin : g_cycles
      assign run[n] = master_en && !halt_q;
    end else begin : g_event
      dram_pmon_evsel #(
        .NUM_LINES (NUM_LINES),
        .ID_W      (ID_W)
      ) u_evsel (
        .code       (ctl_q[n].code),
        .evt_lines  (evt_lines),
        .rd_txn_vld (rd_txn_vld),
        .rd_txn_id  (rd_txn_id),
        .wr_txn_vld (wr_txn_vld),
        .wr_txn_id  (wr_txn_id),
        .filt       (filt_q),
        .ev_hit     (ev_hit[n])
      );
      assign run[n] = ctl_q[n].en && master_en && !halt_q && ev_hit[n];
    end

    dram_pmon_cnt #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_s),
      .clr   (clr[n]),
      .run   (run[n]),
      .cnt_q (cnt_q[n])
    );

    assign cnt_flat[n*CNT_W +: CNT_W] = cnt_q[n];
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (reg_addr == CTL_BASE + 8'(4 * n)) begin
        reg_rdata[CODE_LSB +: 8] = ctl_q[n].code;
        reg_rdata[BIT_EN]        = ctl_q[n].en;
        if (n == 0) reg_rdata[BIT_OVF] = ovf_q;
      end
      if (reg_addr == CNT_BASE + 8'(4 * n)) begin
        reg_rdata[CNT_W-1:0] = cnt_q[n];
      end
    end
    if (reg_addr == FILT_ADDR) begin
      reg_rdata[ID_W-1:0] = filt_q;
    end
  end

  assign irq = ovf_q;

endmodule

// File: rtl/dram_pmon_chk.sv
module dram_pmon_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rst_s,
  input logic                     reg_we,
  input logic [7:0]               reg_addr,
  input logic                     wr_ovf_bit,
  input logic                     irq,
  input logic                     halt,
  input logic                     en0,
  input logic                     wrap0,
  input logic [NUM_CNT-1:0]       clr,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

  logic [CNT_W-1:0] cnt0;
  assign cnt0 = cnt_flat[CNT_W-1:0];

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_clr
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_s)
      clr[n] |=> (cnt_flat[n*CNT_W +: CNT_W] == '0));
  end

  p_cycle_step_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (en0 && !halt && !clr[0]) |=> (cnt0 == $past(cnt0) + 1'b1));

  p_master_gate_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (!en0 && !reg_we) |=> $stable(cnt_flat));

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (halt && !reg_we) |=> $stable(cnt_flat));

  p_irq_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_s)
    wrap0 |=> irq);

  p_irq_only_wrap_r9: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(irq) |-> $past(wrap0));

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_we && (reg_addr == 8'h00) && !wr_ovf_bit && !wrap0) |=> !irq);

endmodule

bind dram_pmon dram_pmon_chk #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .wr_ovf_bit (reg_wdata[0]),
  .irq        (irq),
  .halt       (halt_q),
  .en0        (master_en),
  .wrap0      (wrap0),
  .clr        (clr),
  .cnt_flat   (cnt_flat)
);

// File: tb/tb_dram_pmon.sv
module tb_dram_pmon;

  localparam int NL = 64;
  localparam int IW = 32;

  logic          clk;
  logic          rst_n;
  logic          reg_we;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] evt_lines;
  logic          rd_txn_vld;
  logic [IW-1:0] rd_txn_id;
  logic          wr_txn_vld;
  logic [IW-1:0] wr_txn_id;
  logic          irq;

  int n_chk;
  int n_fail;
  bit done;

  dram_pmon #(
    .NUM_CNT   (4),
    .CNT_W     (8),
    .NUM_LINES (NL),
    .ID_W      (IW)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .evt_lines  (evt_lines),
    .rd_txn_vld (rd_txn_vld),
    .rd_txn_id  (rd_txn_id),
    .wr_txn_vld (wr_txn_vld),
    .wr_txn_id  (wr_txn_id),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000},  // R1 control 0
    '{1'b0, 8'h0C, 32'h0000_0000, 32'h0000_0000},  // R1 control 3
    '{1'b0, 8'h20, 32'h0000_0000, 32'h0000_0000},  // R1 count 0
    '{1'b0, 8'h2C, 32'h0000_0000, 32'h0000_0000},  // R1 count 3
    '{1'b0, 8'h30, 32'h0000_0000, 32'h0000_0000},  // R1 filter
    '{1'b1, 8'h30, 32'hCAFE_0123, 32'hCAFE_0123},  // R2 filter holds 32 bits
    '{1'b1, 8'h04, 32'h0500_0004, 32'h0500_0004},  // R2 code and enable
    '{1'b1, 8'h08, 32'h3100_0006, 32'h3100_0004},  // R2 clear reads 0
    '{1'b1, 8'h00, 32'h0000_0001, 32'h0000_0000},  // R2 flag not settable
    '{1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 unmapped
    '{1'b0, 8'h24, 32'h0000_0000, 32'h0000_0000},  // R2 count 1 idle
    '{1'b1, 8'h04, 32'h0000_0000, 32'h0000_0000}   // R2 disable
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    n_chk      = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    reg_we     = 1'b0;
    reg_addr   = '0;
    reg_wdata  = '0;
    evt_lines  = '0;
    rd_txn_vld = 1'b0;
    rd_txn_id  = '0;
    wr_txn_vld = 1'b0;
    wr_txn_id  = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    chk("R1", "irq after reset", {31'b0, irq}, 32'h0);

    // table of register accesses
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].wdata);
      rd(VECS[i].addr, v);
      chk(i < 5 ? "R1" : "R2", $sformatf("vector %0d", i), v, VECS[i].exp);
    end

    // R3 / R4: arm the cycle counter, nonzero code is ignored
    wr(8'h00, 32'h3700_0006);
    rd(8'h20, v); chk("R3", "count 0 after clear", v, 32'd0);
    idle(5);
    rd(8'h20, v); chk("R4", "count 0 after 5 edges", v, 32'd5);
    rd(8'h00, v); chk("R4", "control 0 readback", v, 32'h3700_0004);

    // R5: line 4 on counter 1, code 0 on counter 2, unmatched code on counter 3
    wr(8'h04, 32'h0400_0006);
    wr(8'h08, 32'h0000_0006);
    wr(8'h0C, 32'h5000_0006);
    evt_lines = '0;
    evt_lines[0] = 1'b1; evt_lines[4] = 1'b1; evt_lines[5] = 1'b1;
    idle(3);
    evt_lines = '0;
    rd(8'h24, v); chk("R5", "code 4 steady strobe", v, 32'd3);
    rd(8'h28, v); chk("R5", "code 0 never counts", v, 32'd0);
    rd(8'h2C, v); chk("R5", "unmatched code", v, 32'd0);
    evt_lines[4] = 1'b1; idle(1);
    evt_lines[4] = 1'b0; idle(1);
    evt_lines[4] = 1'b1; idle(1);
    evt_lines[4] = 1'b0;
    rd(8'h24, v); chk("R5", "code 4 toggling strobe", v, 32'd5);

    // R6 / R10: master off, others hold
    wr(8'h00, 32'h0000_0000);
    rd(8'h20, v); chk("R4", "count 0 at disable", v, 32'd15);
    evt_lines[4] = 1'b1;
    idle(4);
    evt_lines[4] = 1'b0;
    rd(8'h24, v); chk("R6", "count 1 held", v, 32'd5);
    rd(8'h20, v); chk("R10", "count 0 readable", v, 32'd15);
    rd(8'h00, v); chk("R10", "control 0 zero", v, 32'h0);

    // R11: enable only, resume
    wr(8'h00, 32'h0000_0004);
    idle(2);
    rd(8'h20, v); chk("R11", "count 0 resumed", v, 32'd17);

    // R7: ID filtered transactions
    wr(8'h30, 32'h0000_00AB);
    wr(8'h0C, 32'h4100_0006);
    wr(8'h08, 32'h4200_0006);
    rd_txn_vld = 1'b1; rd_txn_id = 32'hAB; wr_txn_vld = 1'b1; wr_txn_id = 32'h12;
    idle(1);
    wr_txn_id = 32'hAB;
    idle(1);
    rd_txn_id = 32'hAC; wr_txn_vld = 1'b0;
    idle(1);
    rd_txn_vld = 1'b0;
    rd(8'h2C, v); chk("R7", "matching reads", v, 32'd2);
    rd(8'h28, v); chk("R7", "matching writes", v, 32'd1);

    // R9: counter 1 wraps while counter 0 is re-armed midway
    wr(8'h04, 32'h0400_0006);
    wr(8'h00, 32'h0000_0006);
    evt_lines[4] = 1'b1;
    idle(199);
    wr(8'h00, 32'h0000_0006);
    idle(59);
    evt_lines[4] = 1'b0;
    rd(8'h24, v); chk("R9", "count 1 wrapped", v, 32'd3);
    rd(8'h20, v); chk("R9", "count 0 not wrapped", v, 32'd59);
    chk("R9", "irq after silent wrap", {31'b0, irq}, 32'h0);
    rd(8'h04, v); chk("R9", "control 1 flag bit", v, 32'h0400_0004);

    // R8: counter 0 rollover
    wr(8'h04, 32'h0400_0006);
    wr(8'h00, 32'h0000_0006);
    idle(1);
    evt_lines[4] = 1'b1;
    idle(254);
    rd(8'h20, v); chk("R8", "count 0 before wrap", v, 32'd255);
    rd(8'h24, v); chk("R8", "count 1 before wrap", v, 32'd254);
    chk("R8", "irq before wrap", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R8", "irq after wrap", {31'b0, irq}, 32'h1);
    idle(5);
    rd(8'h20, v); chk("R8", "count 0 frozen", v, 32'd0);
    rd(8'h24, v); chk("R8", "count 1 frozen", v, 32'd255);
    rd(8'h00, v); chk("R8", "control 0 flag", v, 32'h0000_0005);

    // R10: clear the flag without re-arm, freeze stays
    wr(8'h00, 32'h0000_0004);
    chk("R10", "irq cleared", {31'b0, irq}, 32'h0);
    idle(3);
    rd(8'h24, v); chk("R8", "still frozen after flag clear", v, 32'd255);
    wr(8'h00, 32'h0000_0006);
    idle(3);
    rd(8'h20, v); chk("R8", "count 0 after re-arm", v, 32'd3);
    rd(8'h24, v); chk("R8", "count 1 after re-arm", v, 32'd2);

    // R10: disable counter 1 while its strobe is high
    wr(8'h04, 32'h0000_0000);
    idle(3);
    evt_lines[4] = 1'b0;
    rd(8'h04, v); chk("R10", "control 1 zero", v, 32'h0);
    rd(8'h24, v); chk("R10", "count 1 held", v, 32'd3);

    // R1: reset during activity
    rst_n = 1'b0;
    #2;
    rd(8'h20, v); chk("R1", "count 0 in reset", v, 32'h0);
    rd(8'h00, v); chk("R1", "control 0 in reset", v, 32'h0);
    rd(8'h30, v); chk("R1", "filter in reset", v, 32'h0);
    chk("R1", "irq in reset", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule